// File: doc/BRIEF.md
# Variable-Length Double-Buffer Sequencer

This block is the control unit that sits around a column-rotation datapath fed from an input buffer and feeding an output buffer. Transform blocks of 4, 8, 16 or 32 columns arrive as a continuous stream, each announced by a request carrying a 2-bit length code. For every block the sequencer runs three activities in turn: it loads the columns into the input buffer, turns them (reads each column from the input buffer, addresses the coefficient table, and writes the rotated result into the output buffer a fixed number of cycles later), and drains the finished columns from the output buffer. The drain of earlier results overlaps the load and the turn of later blocks, so both data flows keep moving.

The output buffer is a 32-entry ring. Each block is written starting at the slot just past the last column still owned by earlier blocks, which equals the read pointer plus the count of columns not yet read. When a short block follows a long one, this offset keeps the longer block's unread columns intact; when a long block follows a short one, the earlier block has already drained and the offset collapses to the read pointer. A block may start turning only if the ring has room for all of its columns, and a block is drained only once all of its columns are written, because the rotated data of a block is only complete as a whole.

Top module: `dbuf_seq`

## Requirements
- R1: While reset is held and after reset with no request, `take`, all enables and `phase` are zero.
- R2: A request is taken (`take` high in the cycle it is presented) only when no load is running; the load then writes input-buffer columns 0 to N-1 on N consecutive cycles starting the next cycle, where N = 4 << `req_len` (code 0..3 gives 4, 8, 16, 32).
- R3: The turn of a block reads input-buffer columns 0 to N-1 on N consecutive cycles, with `rom_addr` = (N - 4) + column, and each column read is the one loaded for that block.
- R4: Every input-buffer read is followed by exactly one output-buffer write exactly PIPE cycles later (PIPE = 4 by default), and no write occurs otherwise.
- R5: An output write never lands on a slot that holds a column not yet read; at most 32 columns are reserved at any time.
- R6: Reads of the output buffer walk the ring one slot per cycle, return every column of every block exactly once in block order and column order, and begin on a block only after all its columns are written.
- R7: A load and a turn are never active in the same cycle.
- R8: When a request is pending in the cycle of a turn's last read, it is taken in that cycle, so load-while-draining and turn-while-draining both occur in a mixed stream.
- R9: For an isolated block the first output read comes exactly 2N + PIPE cycles after its first input write (68 cycles for N = 32).
- R10: `phase` encodes the activities: 0 idle, 1 load only, 2 turn only, 3 load and drain, 4 turn and drain, 5 drain only.
- R11: Each block's first output write uses slot (read pointer + unread columns) mod 32, so output writes walk the ring contiguously across blocks of any length order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | A block is offered |
| req_len | input | 2 | Length code of the offered block |
| take | output | 1 | Offered block accepted this cycle |
| in_wr_en | output | 1 | Input-buffer write enable |
| in_wr_addr | output | 5 | Input-buffer write column |
| in_rd_en | output | 1 | Input-buffer read enable (turn active) |
| in_rd_addr | output | 5 | Input-buffer read column |
| rom_addr | output | 6 | Coefficient-table address |
| out_wr_en | output | 1 | Output-buffer write enable |
| out_wr_addr | output | 5 | Output-buffer write slot |
| out_rd_en | output | 1 | Output-buffer read enable |
| out_rd_addr | output | 5 | Output-buffer read slot |
| phase | output | 3 | Current activity group |

## Verification
A wrong reserved-column count or write pointer shows as an output write onto a slot whose column has not been read, or as a read that returns a column out of order, within one block length of the fault. A lost or stale input-buffer flag shows as a turn that reads a column from the wrong block, or as a stream that stalls, which the bench sees as missing reads. Off-by-one errors in the column counters show at the first block of the affected length as a wrong `rom_addr`, an extra or missing write, or a latency differing from 2N + PIPE.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_LOAD       = 3'd1,
    PH_TURN       = 3'd2,
    PH_LOAD_DRAIN = 3'd3,
    PH_TURN_DRAIN = 3'd4,
    PH_DRAIN      = 3'd5
  } phase_e;

  // columns in a block of the given length code
  function automatic logic [5:0] blk_cols(input logic [1:0] code);
    return 6'd4 << code;
  endfunction

  // first coefficient entry of a length: tables packed 4, 8, 16, 32
  function automatic logic [5:0] coef_base(input logic [1:0] code);
    return blk_cols(code) - 6'd4;
  endfunction

  // a block fits if reserved plus its columns stays within capacity
  function automatic logic fits(input logic [6:0] used, input logic [1:0] code,
                                input logic [6:0] cap);
    return (used + {1'b0, blk_cols(code)}) <= cap;
  endfunction

  function automatic phase_e phase_of(input logic load, input logic turn,
                                      input logic drain);
    case ({load, turn, drain})
      3'b100:  return PH_LOAD;
      3'b010:  return PH_TURN;
      3'b101:  return PH_LOAD_DRAIN;
      3'b011:  return PH_TURN_DRAIN;
      3'b001:  return PH_DRAIN;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dbs_fill_ctl.sv
module dbs_fill_ctl
  import dbs_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    req_len,
  input  logic          turn_busy,
  input  logic          turn_last,
  input  logic          ibuf_full,
  output logic          take,
  output logic          fill_busy,
  output logic          fill_last,
  output logic [1:0]    fill_code,
  output logic [AW-1:0] fill_col
);
  localparam int LW = AW + 1;

  // the input buffer is free once the turn issues its final read
  assign take      = req & ~fill_busy & ~ibuf_full & (~turn_busy | turn_last);
  assign fill_last = fill_busy &
                     (LW'(fill_col) == LW'(blk_cols(fill_code)) - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_busy <= 1'b0;
      fill_col  <= '0;
      fill_code <= '0;
    end else if (take) begin
      fill_busy <= 1'b1;
      fill_col  <= '0;
      fill_code <= req_len;
    end else if (fill_busy) begin
      if (fill_last) fill_busy <= 1'b0;
      else           fill_col  <= fill_col + 1'b1;
    end
  end
endmodule

// File: rtl/dbs_turn_ctl.sv
module dbs_turn_ctl
  import dbs_pkg::*;
#(
  parameter int COLS = 32,
  parameter int PIPE = 4,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_last,
  input  logic [1:0]    fill_code,
  input  logic [AW:0]   occ,
  output logic          turn_go,
  output logic          turn_busy,
  output logic          turn_last,
  output logic          ibuf_full,
  output logic [AW-1:0] rd_col,
  output logic [AW:0]   rom_addr,
  output logic [AW-1:0] next_wr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          blk_done,
  output logic [1:0]    done_code
);
  localparam int LW = AW + 1;

  typedef struct packed {
    logic          v;
    logic          last;
    logic [1:0]    code;
    logic [AW-1:0] addr;
  } stage_t;

  logic [1:0] ibuf_code, turn_code, cand_code;
  logic       cand;
  stage_t     head;

  // a block is ready to turn if held in the buffer or finishing its load now
  assign cand      = ibuf_full | fill_last;
  assign cand_code = ibuf_full ? ibuf_code : fill_code;
  assign turn_go   = cand & ~turn_busy & fits(7'(occ), cand_code, 7'(COLS));
  assign turn_last = turn_busy &
                     (LW'(rd_col) == LW'(blk_cols(turn_code)) - LW'(1));
  assign rom_addr  = LW'(coef_base(turn_code)) + LW'(rd_col);
  assign head      = '{v: turn_busy, last: turn_last, code: turn_code, addr: next_wr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibuf_full <= 1'b0;
      ibuf_code <= '0;
    end else begin
      if (fill_last) ibuf_code <= fill_code;
      if (turn_go)        ibuf_full <= 1'b0;
      else if (fill_last) ibuf_full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_busy <= 1'b0;
      turn_code <= '0;
      rd_col    <= '0;
      next_wr   <= '0;
    end else begin
      if (turn_go) begin
        turn_busy <= 1'b1;
        turn_code <= cand_code;
        rd_col    <= '0;
      end else if (turn_busy) begin
        if (turn_last) turn_busy <= 1'b0;
        else           rd_col    <= rd_col + 1'b1;
      end
      if (turn_busy) next_wr <= next_wr + 1'b1;
    end
  end

  // datapath latency: one register stage per cycle of the rotation pipeline
  for (genvar g = 0; g < PIPE; g++) begin : g_st
    stage_t d, q;
    if (g == 0) begin : g_head
      assign d = head;
    end else begin : g_link
      assign d = g_st[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign wr_en     = g_st[PIPE-1].q.v;
  assign wr_addr   = g_st[PIPE-1].q.addr;
  assign blk_done  = g_st[PIPE-1].q.v & g_st[PIPE-1].q.last;
  assign done_code = g_st[PIPE-1].q.code;
endmodule

// File: rtl/dbs_drain_ctl.sv
module dbs_drain_ctl
  import dbs_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          blk_done,
  input  logic [1:0]    done_code,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   occ
);
  localparam int LW = AW + 1;

  logic [AW:0] rdy;   // columns of completed blocks not yet read

  assign rd_en = (rdy != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy     <= '0;
      occ     <= '0;
      rd_addr <= '0;
    end else begin
      occ <= occ + LW'(issue) - LW'(rd_en);
      rdy <= rdy + (blk_done ? LW'(blk_cols(done_code)) : LW'(0)) - LW'(rd_en);
      if (rd_en) rd_addr <= rd_addr + 1'b1;
    end
  end
endmodule

// File: rtl/dbuf_seq.sv
module dbuf_seq
  import dbs_pkg::*;
#(
  parameter int COLS = 32,
  parameter int PIPE = 4,
  localparam int AW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    req_len,
  output logic          take,
  output logic          in_wr_en,
  output logic [AW-1:0] in_wr_addr,
  output logic          in_rd_en,
  output logic [AW-1:0] in_rd_addr,
  output logic [AW:0]   rom_addr,
  output logic          out_wr_en,
  output logic [AW-1:0] out_wr_addr,
  output logic          out_rd_en,
  output logic [AW-1:0] out_rd_addr,
  output logic [2:0]    phase
);
  // named internal events, also used by the bound checker
  logic          fill_busy, fill_last, turn_go, turn_busy, turn_last, ibuf_full;
  logic          blk_done;
  logic [1:0]    fill_code, done_code;
  logic [AW:0]   occ;
  logic [AW-1:0] next_wr, slot_gap;

  dbs_fill_ctl #(.AW(AW)) u_fill (
    .clk, .rst_n, .req, .req_len, .turn_busy, .turn_last, .ibuf_full,
    .take, .fill_busy, .fill_last, .fill_code, .fill_col(in_wr_addr)
  );

  dbs_turn_ctl #(.COLS(COLS), .PIPE(PIPE), .AW(AW)) u_turn (
    .clk, .rst_n, .fill_last, .fill_code, .occ,
    .turn_go, .turn_busy, .turn_last, .ibuf_full,
    .rd_col(in_rd_addr), .rom_addr, .next_wr,
    .wr_en(out_wr_en), .wr_addr(out_wr_addr), .blk_done, .done_code
  );

  dbs_drain_ctl #(.AW(AW)) u_drain (
    .clk, .rst_n, .issue(turn_busy), .blk_done, .done_code,
    .rd_en(out_rd_en), .rd_addr(out_rd_addr), .occ
  );

  assign in_wr_en = fill_busy;
  assign in_rd_en = turn_busy;
  assign slot_gap = next_wr - out_rd_addr;
  assign phase    = phase_of(fill_busy, turn_busy, out_rd_en);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int COLS = 32,
  parameter int PIPE = 4,
  parameter int AW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take,
  input logic          fill_busy,
  input logic          turn_busy,
  input logic          turn_go,
  input logic [AW:0]   occ,
  input logic [AW-1:0] slot_gap,
  input logic          in_rd_en,
  input logic          out_wr_en,
  input logic          out_rd_en,
  input logic [AW-1:0] out_rd_addr,
  input logic [2:0]    phase
);
  int inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else        inflight <= inflight + int'(in_rd_en) - int'(out_wr_en);
  end

  AST_LOAD_TURN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_busy && turn_busy)); // R7
  AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !fill_busy); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(COLS)); // R5
  AST_GAP_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    turn_go |-> (slot_gap == occ[AW-1:0])); // R11
  AST_PIPE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= PIPE); // R4
  AST_WR_HAS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> (inflight != 0)); // R4
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_rd_en |=> (out_rd_addr == AW'($past(out_rd_addr) + 1'b1))); // R6
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd5); // R10
endmodule

bind dbuf_seq dbs_checker #(.COLS(COLS), .PIPE(PIPE), .AW(AW)) u_chk (
  .clk, .rst_n, .take, .fill_busy, .turn_busy, .turn_go, .occ, .slot_gap,
  .in_rd_en, .out_wr_en, .out_rd_en, .out_rd_addr, .phase
);

// File: tb/tb_dbuf_seq.sv
module tb_dbuf_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 32;
  localparam int PIPE = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [1:0] req_len = '0;
  logic take, in_wr_en, in_rd_en, out_wr_en, out_rd_en;
  logic [4:0] in_wr_addr, in_rd_addr, out_wr_addr, out_rd_addr;
  logic [5:0] rom_addr;
  logic [2:0] phase;

  dbuf_seq #(.COLS(COLS), .PIPE(PIPE)) dut (
    .clk, .rst_n, .req, .req_len, .take, .in_wr_en, .in_wr_addr, .in_rd_en,
    .in_rd_addr, .rom_addr, .out_wr_en, .out_wr_addr, .out_rd_en,
    .out_rd_addr, .phase
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, nsub = 0, nread = 0;
  int blk_code[128], first_wr[128], first_rd[128], wcnt[128];
  int sub_q[$];
  int inmem[32], omem[32], sched[16];
  bit ovalid[32];
  int fill_b = -1, fill_col = 0, last_filled = -1, rot_b = -1, rot_col = 0;
  int exp_w = 0, exp_r = 0, rb = 0, rc = 0, seen_wb = 0, seen_rwb = 0;
  bit run = 1'b0, done = 1'b0;

  function automatic int ncols(input int b);
    return 4 << blk_code[b];
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic submit(input int code);
    blk_code[nsub] = code;
    wcnt[nsub] = 0;
    sub_q.push_back(nsub);
    nsub++;
  endtask

  task automatic settle();
    while (nread != nsub) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: drive the request, then sample the cycle's outputs
  initial begin : mon
    wait (run);
    forever begin
      @(negedge clk);
      req     = (sub_q.size() != 0);
      req_len = req ? 2'(blk_code[sub_q[0]]) : 2'd0;
      #1;
      cyc++;
      begin
        int exp_ph, tag, e, n;
        bit last_rot;
        last_rot = 1'b0;
        chk(!(in_wr_en && in_rd_en), "R7 load/turn overlap", int'(in_rd_en), 0);
        case ({in_wr_en, in_rd_en, out_rd_en})
          3'b100: exp_ph = 1;  3'b010: exp_ph = 2;  3'b101: exp_ph = 3;
          3'b011: exp_ph = 4;  3'b001: exp_ph = 5;  default: exp_ph = 0;
        endcase
        chk(int'(phase) == exp_ph, "R10 phase", int'(phase), exp_ph);
        if (exp_ph == 3) seen_wb++;
        if (exp_ph == 4) seen_rwb++;
        // load
        if (fill_b >= 0) begin
          chk(in_wr_en, "R2 load enable", int'(in_wr_en), 1);
          if (in_wr_en) begin
            chk(int'(in_wr_addr) == fill_col, "R2 load column", int'(in_wr_addr), fill_col);
            if (fill_col == 0) first_wr[fill_b] = cyc;
            inmem[in_wr_addr] = fill_b * 64 + fill_col;
            fill_col++;
            if (fill_col == ncols(fill_b)) begin last_filled = fill_b; fill_b = -1; end
          end
        end else chk(!in_wr_en, "R2 stray load", int'(in_wr_en), 0);
        // turn
        if (in_rd_en) begin
          if (rot_b < 0) begin rot_b = last_filled; rot_col = 0; end
          n = ncols(rot_b);
          chk(int'(in_rd_addr) == rot_col, "R3 read column", int'(in_rd_addr), rot_col);
          chk(int'(rom_addr) == n - 4 + rot_col, "R3 rom address", int'(rom_addr), n - 4 + rot_col);
          tag = inmem[in_rd_addr];
          chk(tag == rot_b * 64 + rot_col, "R3 column source", tag, rot_b * 64 + rot_col);
          sched[(cyc + PIPE) % 16] = tag + 1;
          last_rot = (rot_col == n - 1);
          rot_col++;
          if (rot_col == n) rot_b = -1;
        end
        if (in_rd_en && last_rot && req) chk(take, "R8 take at last read", int'(take), 1);
        if (take) begin
          chk(req && !in_wr_en, "R2 take while loading", int'(in_wr_en), 0);
          fill_b = sub_q.pop_front();
          fill_col = 0;
        end
        // output write
        e = sched[cyc % 16];
        sched[cyc % 16] = 0;
        chk(out_wr_en == (e != 0), "R4 write timing", int'(out_wr_en), int'(e != 0));
        if (out_wr_en && e != 0) begin
          chk(int'(out_wr_addr) == exp_w, "R11 write slot", int'(out_wr_addr), exp_w);
          chk(!ovalid[out_wr_addr], "R5 overwrite of unread", int'(ovalid[out_wr_addr]), 0);
          omem[out_wr_addr] = e - 1;
          ovalid[out_wr_addr] = 1'b1;
          wcnt[(e - 1) / 64]++;
          exp_w = (exp_w + 1) % COLS;
        end
        // drain
        if (out_rd_en) begin
          chk(ovalid[out_rd_addr], "R6 read of empty slot", int'(ovalid[out_rd_addr]), 1);
          chk(omem[out_rd_addr] == rb * 64 + rc, "R6 order", omem[out_rd_addr], rb * 64 + rc);
          chk(int'(out_rd_addr) == exp_r, "R6 read slot", int'(out_rd_addr), exp_r);
          chk(rb < nsub && wcnt[rb] == ncols(rb), "R6 block complete", wcnt[rb], ncols(rb));
          if (rc == 0) first_rd[rb] = cyc;
          ovalid[out_rd_addr] = 1'b0;
          exp_r = (exp_r + 1) % COLS;
          rc++;
          if (rc == ncols(rb)) begin rb++; rc = 0; nread++; end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL R6 watchdog blocks_read=%0d expected=%0d", nread, nsub);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    // R1: quiet during reset
    chk(!take && !in_wr_en && !in_rd_en && !out_wr_en && !out_rd_en,
        "R1 enables in reset", int'({take, in_wr_en, in_rd_en, out_wr_en, out_rd_en}), 0);
    chk(phase == 3'd0, "R1 phase in reset", int'(phase), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(!in_wr_en && !out_rd_en && phase == 3'd0, "R1 idle after reset", int'(phase), 0);

    // R9: isolated blocks of every length
    for (int c = 0; c < 4; c++) begin
      int b;
      b = nsub;
      submit(c);
      settle();
      chk(first_rd[b] - first_wr[b] == 2 * (4 << c) + PIPE, "R9 latency",
          first_rd[b] - first_wr[b], 2 * (4 << c) + PIPE);
    end

    // every ordered pair of lengths back to back, then a long/short burst
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        submit(a);
        submit(b);
      end
    submit(3); submit(0); submit(1); submit(0); submit(3); submit(3); submit(2);
    settle();
    chk(seen_wb > 0, "R8 load while draining seen", seen_wb, 1);
    chk(seen_rwb > 0, "R8 turn while draining seen", seen_rwb, 1);
    chk(nread == nsub, "R6 all blocks read", nread, nsub);
    chk(phase == 3'd0 && !out_wr_en, "R1 idle at end", int'(phase), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule